// File: doc/BRIEF.md
# Serial Flash Command Responder

This block is the target side of a serial flash link, written as synthesizable logic with a small byte-wide memory inside it. It recognises a read-identification command and two fast-read commands, and stays silent for any other command. A host controller, or a test environment that stands in for a flash device, connects to it over four wires: a serial clock, an active-low select, a host-to-target data line and a target-to-host data line. In the dual-output read the host-to-target line turns around, and the block drives it for the length of the data phase.

The block samples the serial clock, select and host data with its own system clock. It takes input bits on serial-clock rising edges and changes its outputs after serial-clock falling edges, so the host can sample on the rising edge. A 24-bit identification word is applied on a port. The memory image is written byte by byte through a load port before the host reads it. Each data line has its own output enable, and both enables drop at once when the select goes high.

Top module: `flash_cmd_responder`

## Requirements
- R1: After each high-to-low select transition, the first 8 bits sampled on serial-clock rising edges, most significant bit first, are the command code. A select period that ends before 8 bits arrive leaves no trace in the next one.
- R2: For a command code other than 9Fh, 0Bh or 3Bh, both output enables stay low until select goes high. The next select period decodes a new command as usual.
- R3: Command 9Fh sends id_word[23:16], then id_word[15:8], then id_word[7:0], each most significant bit first on miso_out. While select stays low, the sequence starts again with id_word[23:16].
- R4: Command 0Bh takes a 24-bit address most significant bit first, then 8 dummy clocks. It then sends memory bytes most significant bit first on miso_out, one bit per serial clock.
- R5: Command 3Bh uses the same address and dummy framing and sends two bits per serial clock. Byte bits 7, 5, 3, 1 go on miso_out and bits 6, 4, 2, 0 go on mosi_out, in that order.
- R6: mosi_oe is high only during the data phase of command 3Bh. Neither enable is high from reset, during the command, address and dummy bits, or in any phase of commands 9Fh and 0Bh (mosi_oe).
- R7: The read address goes up by one after each byte and wraps from DEPTH-1 to 0. Address bits at and above log2(DEPTH) are ignored.
- R8: miso_out and mosi_out change only after a serial-clock falling edge and hold steady through the following high phase.
- R9: Both output enables go low in the same cycle as cs_n goes high, including in the middle of a data byte.
- R10: When ld_we is high at a clk rising edge, ld_data is stored at memory location ld_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| mosi_in | input | 1 | Host-to-target serial data |
| mosi_out | output | 1 | Target drive of the host-to-target line in dual read |
| mosi_oe | output | 1 | Enable for mosi_out |
| miso_out | output | 1 | Target-to-host serial data |
| miso_oe | output | 1 | Enable for miso_out |
| id_word | input | 24 | Identification bytes: manufacturer, type, capacity |
| ld_we | input | 1 | Memory load strobe |
| ld_addr | input | log2(DEPTH) | Memory load address |
| ld_data | input | 8 | Memory load byte |

## Verification
With two sampling stages, a data-line update appears on the third clk rising edge after the serial clock falls. The command decode, and the load of the first byte, appear on the third edge after the serial clock rises. The bench holds each serial-clock phase for six clk cycles. It reads the data lines and enables at the end of the low phase, just before it raises the serial clock, and compares them again at the end of the high phase. This is how R8's stability is checked. The enables drop in the same cycle that cs_n rises, so that check samples 1 ns after the bench raises cs_n, before any clock edge.

// File: rtl/fr_pkg.sv
package fr_pkg;
   localparam logic [7:0] OP_READ_ID   = 8'h9F;
   localparam logic [7:0] OP_FAST_READ = 8'h0B;
   localparam logic [7:0] OP_DUAL_READ = 8'h3B;

   localparam int CMD_BITS   = 8;
   localparam int ADDR_BITS  = 24;
   localparam int DUMMY_BITS = 8;
   localparam int ID_BYTES   = 3;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_ADDR,
      PH_DUMMY,
      PH_DATA,
      PH_MUTE
   } phase_t;

   typedef enum logic [1:0] {
      RM_ID,
      RM_SINGLE,
      RM_DUAL
   } rmode_t;
endpackage

// File: rtl/fr_sampler.sv
module fr_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic sel,
   output logic mosi_s
);
   if (STAGES < 1) begin : g_bad_stages
      $error("fr_sampler: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sclk_p;
   logic [STAGES-1:0] cs_p;
   logic [STAGES-1:0] mosi_p;
   logic              sclk_last;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
         end else begin
            sclk_p <= sclk;
            cs_p   <= cs_n;
            mosi_p <= mosi;
         end
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
         end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_last <= 1'b0;
      else        sclk_last <= sclk_p[STAGES-1];
   end

   assign sclk_rise = sclk_p[STAGES-1] & ~sclk_last;
   assign sclk_fall = ~sclk_p[STAGES-1] & sclk_last;
   assign sel       = ~cs_p[STAGES-1];
   assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/fr_cmd_decode.sv
module fr_cmd_decode
   import fr_pkg::*;
#(
   parameter int AW      = 8,
   parameter int DUAL_EN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          rise,
   input  logic          mosi_s,
   output phase_t        phase,
   output rmode_t        rmode,
   output logic [AW-1:0] start_addr,
   output logic          load_rd
);
   localparam int CW = $clog2(ADDR_BITS + 1);

   if (AW < 2 || AW > ADDR_BITS) begin : g_bad_aw
      $error("fr_cmd_decode: AW out of range");
   end

   logic [CW-1:0] cnt;
   logic [6:0]    op_sh;
   logic [AW-1:0] adr_sh;
   logic [7:0]    op_now;
   logic          dual_ok;
   phase_t        dec_phase;
   rmode_t        dec_mode;
   logic          dec_load;

   if (DUAL_EN != 0) begin : g_dual_on
      assign dual_ok = 1'b1;
   end else begin : g_dual_off
      assign dual_ok = 1'b0;
   end

   assign op_now     = {op_sh, mosi_s};
   assign start_addr = adr_sh;

   always_comb begin
      dec_phase = PH_MUTE;
      dec_mode  = RM_SINGLE;
      dec_load  = 1'b0;
      case (op_now)
         OP_READ_ID: begin
            dec_phase = PH_DATA;
            dec_mode  = RM_ID;
            dec_load  = 1'b1;
         end
         OP_FAST_READ: begin
            dec_phase = PH_ADDR;
            dec_mode  = RM_SINGLE;
         end
         OP_DUAL_READ: begin
            if (dual_ok) begin
               dec_phase = PH_ADDR;
               dec_mode  = RM_DUAL;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_OPCODE;
         rmode   <= RM_SINGLE;
         cnt     <= '0;
         op_sh   <= '0;
         adr_sh  <= '0;
         load_rd <= 1'b0;
      end else begin
         load_rd <= 1'b0;
         if (!sel) begin
            phase <= PH_OPCODE;
            cnt   <= '0;
         end else if (rise) begin
            case (phase)
               PH_OPCODE: begin
                  op_sh <= op_now[6:0];
                  if (cnt == CW'(CMD_BITS - 1)) begin
                     cnt     <= '0;
                     phase   <= dec_phase;
                     rmode   <= dec_mode;
                     load_rd <= dec_load;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               PH_ADDR: begin
                  adr_sh <= {adr_sh[AW-2:0], mosi_s};
                  if (cnt == CW'(ADDR_BITS - 1)) begin
                     cnt   <= '0;
                     phase <= PH_DUMMY;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               PH_DUMMY: begin
                  if (cnt == CW'(DUMMY_BITS - 1)) begin
                     cnt     <= '0;
                     phase   <= PH_DATA;
                     load_rd <= 1'b1;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/fr_mem.sv
module fr_mem #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("fr_mem: DEPTH must equal 2**AW");
   end

   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/fr_serializer.sv
module fr_serializer
   import fr_pkg::*;
#(
   parameter int AW      = 8,
   parameter int ID_WRAP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          fall,
   input  phase_t        phase,
   input  rmode_t        rmode,
   input  logic          load_rd,
   input  logic [AW-1:0] start_addr,
   input  logic [23:0]   id_word,
   input  logic [7:0]    mem_rdata,
   output logic [AW-1:0] mem_raddr,
   output logic          miso_d,
   output logic          mosi_d,
   output logic          miso_en,
   output logic          mosi_en
);
   localparam int IW = $clog2(ID_BYTES);

   logic [2:0]    pos;
   logic [AW-1:0] ptr;
   logic [IW-1:0] id_idx;
   logic [IW-1:0] id_next;
   logic [7:0]    id_byte;
   logic [7:0]    cur_byte;
   logic [2:0]    bitoff;
   logic [7:0]    shifted;
   logic          last;
   logic          is_dual;

   localparam logic [IW-1:0] ID_LAST = IW'(ID_BYTES - 1);

   if (ID_WRAP != 0) begin : g_id_wrap
      assign id_next = (id_idx == ID_LAST) ? '0 : id_idx + IW'(1);
   end else begin : g_id_hold
      assign id_next = (id_idx == ID_LAST) ? ID_LAST : id_idx + IW'(1);
   end

   always_comb begin
      case (id_idx)
         IW'(0):  id_byte = id_word[23:16];
         IW'(1):  id_byte = id_word[15:8];
         default: id_byte = id_word[7:0];
      endcase
   end

   assign is_dual   = (rmode == RM_DUAL);
   assign cur_byte  = (rmode == RM_ID) ? id_byte : mem_rdata;
   assign bitoff    = is_dual ? {pos[1:0], 1'b0} : pos;
   assign shifted   = cur_byte << bitoff;
   assign last      = is_dual ? (pos == 3'd3) : (pos == 3'd7);
   assign mem_raddr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         ptr     <= '0;
         id_idx  <= '0;
         miso_d  <= 1'b0;
         mosi_d  <= 1'b0;
         miso_en <= 1'b0;
         mosi_en <= 1'b0;
      end else if (!sel) begin
         pos     <= '0;
         miso_en <= 1'b0;
         mosi_en <= 1'b0;
      end else if (load_rd) begin
         ptr    <= start_addr;
         id_idx <= '0;
         pos    <= '0;
      end else if (fall && phase == PH_DATA) begin
         miso_d  <= shifted[7];
         mosi_d  <= shifted[6];
         miso_en <= 1'b1;
         mosi_en <= is_dual;
         if (last) begin
            pos <= '0;
            if (rmode == RM_ID) id_idx <= id_next;
            else                ptr    <= ptr + AW'(1);
         end else begin
            pos <= pos + 3'd1;
         end
      end
   end
endmodule

// File: rtl/flash_cmd_responder.sv
module flash_cmd_responder
   import fr_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter int DUAL_EN     = 1,
   parameter int ID_WRAP     = 1,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sclk,
   input  logic          cs_n,
   input  logic          mosi_in,
   output logic          mosi_out,
   output logic          mosi_oe,
   output logic          miso_out,
   output logic          miso_oe,
   input  logic [23:0]   id_word,
   input  logic          ld_we,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_data
);
   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("flash_cmd_responder: DEPTH must be a power of two, at least 4");
   end
   if (AW > ADDR_BITS) begin : g_bad_span
      $error("flash_cmd_responder: DEPTH exceeds the address span");
   end

   logic          sclk_rise;
   logic          sclk_fall;
   logic          sel;
   logic          mosi_s;
   phase_t        phase;
   rmode_t        rmode;
   logic [AW-1:0] start_addr;
   logic          load_rd;
   logic [AW-1:0] mem_raddr;
   logic [7:0]    mem_rdata;
   logic          miso_en;
   logic          mosi_en;

   fr_sampler #(.STAGES(SYNC_STAGES)) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .mosi      (mosi_in),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .sel       (sel),
      .mosi_s    (mosi_s)
   );

   fr_cmd_decode #(.AW(AW), .DUAL_EN(DUAL_EN)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .rise       (sclk_rise),
      .mosi_s     (mosi_s),
      .phase      (phase),
      .rmode      (rmode),
      .start_addr (start_addr),
      .load_rd    (load_rd)
   );

   fr_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (ld_we),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   fr_serializer #(.AW(AW), .ID_WRAP(ID_WRAP)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .fall       (sclk_fall),
      .phase      (phase),
      .rmode      (rmode),
      .load_rd    (load_rd),
      .start_addr (start_addr),
      .id_word    (id_word),
      .mem_rdata  (mem_rdata),
      .mem_raddr  (mem_raddr),
      .miso_d     (miso_out),
      .mosi_d     (mosi_out),
      .miso_en    (miso_en),
      .mosi_en    (mosi_en)
   );

   assign miso_oe = miso_en & ~cs_n;
   assign mosi_oe = mosi_en & ~cs_n;
endmodule

// File: rtl/fr_chk.sv
module fr_chk
   import fr_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   miso_oe,
   input logic   mosi_oe,
   input logic   miso_out,
   input logic   mosi_out,
   input logic   sclk_fall,
   input phase_t phase
);
   p_dual_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mosi_oe |-> miso_oe)
      else $error("p_dual_pair_r5");

   p_mute_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MUTE) |-> (!miso_oe && !mosi_oe))
      else $error("p_mute_silent_r2");

   p_header_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR || phase == PH_DUMMY) |-> (!miso_oe && !mosi_oe))
      else $error("p_header_quiet_r6");

   p_miso_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso_out) |-> $past(sclk_fall))
      else $error("p_miso_on_fall_r8");

   p_mosi_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi_out) |-> $past(sclk_fall))
      else $error("p_mosi_on_fall_r8");
endmodule

bind flash_cmd_responder fr_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .miso_oe   (miso_oe),
   .mosi_oe   (mosi_oe),
   .miso_out  (miso_out),
   .mosi_out  (mosi_out),
   .sclk_fall (sclk_fall),
   .phase     (phase)
);

// File: tb/flash_cmd_responder_bench.sv
module flash_cmd_responder_bench;
   localparam int HALF = 6;
   localparam logic [7:0] C_ID   = 8'h9F;
   localparam logic [7:0] C_FAST = 8'h0B;
   localparam logic [7:0] C_DUAL = 8'h3B;
   localparam logic [23:0] ID_VAL = 24'h5A3C17;
   localparam int NV = 7;
   // {opcode, address, byte count}
   localparam logic [35:0] VECS [NV] = '{
      {C_ID,   24'h000000, 4'd5},
      {C_FAST, 24'h000010, 4'd3},
      {C_DUAL, 24'h000020, 4'd4},
      {C_FAST, 24'h0000FE, 4'd4},
      {C_DUAL, 24'h1230FF, 4'd3},
      {8'h03,  24'h000000, 4'd2},
      {C_ID,   24'h000000, 4'd3}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       mosi_in = 1'b0;
   logic       mosi_out, mosi_oe, miso_out, miso_oe;
   logic       ld_we = 1'b0;
   logic [7:0] ld_addr = '0;
   logic [7:0] ld_data = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [7:0] img [256];
   logic [7:0] rx [16];
   logic hdr_oe, all_miso_oe, any_miso_oe, all_mosi_oe, any_mosi_oe, all_stable;

   always #2 clk = ~clk;

   flash_cmd_responder u_flash_cmd_responder (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi_in(mosi_in),
      .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_out(miso_out), .miso_oe(miso_oe),
      .id_word(ID_VAL), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
      img[a] = d;
   endtask

   task automatic tick(input logic b, output logic so, output logic si,
                       output logic moe, output logic soe, output logic st);
      mosi_in = b;
      repeat (HALF) @(negedge clk);
      so = miso_out; si = mosi_out; moe = miso_oe; soe = mosi_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      st = (miso_out == so) && (mosi_out == si) && (miso_oe == moe) && (mosi_oe == soe);
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      logic so, si, moe, soe, st;
      for (int i = 7; i >= 0; i--) begin
         tick(v[i], so, si, moe, soe, st);
         hdr_oe = hdr_oe | moe | soe;
      end
   endtask

   task automatic get_bytes(input bit dual, input int n);
      logic so, si, moe, soe, st;
      logic [7:0] b;
      for (int k = 0; k < n; k++) begin
         b = '0;
         for (int j = 0; j < (dual ? 4 : 8); j++) begin
            tick(1'b0, so, si, moe, soe, st);
            b = dual ? {b[5:0], so, si} : {b[6:0], so};
            all_miso_oe = all_miso_oe & moe;
            any_miso_oe = any_miso_oe | moe;
            all_mosi_oe = all_mosi_oe & soe;
            any_mosi_oe = any_mosi_oe | soe;
            all_stable  = all_stable & st;
         end
         rx[k] = b;
      end
   endtask

   task automatic xfer(input logic [7:0] op, input logic [23:0] addr, input int n);
      hdr_oe = 0; all_miso_oe = 1; any_miso_oe = 0;
      all_mosi_oe = 1; any_mosi_oe = 0; all_stable = 1;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      send_byte(op);
      if (op == C_FAST || op == C_DUAL) begin
         send_byte(addr[23:16]);
         send_byte(addr[15:8]);
         send_byte(addr[7:0]);
         send_byte(8'h00);
      end
      get_bytes(op == C_DUAL, n);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   function automatic logic [7:0] id_at(input int k);
      case (k % 3)
         0:       return ID_VAL[23:16];
         1:       return ID_VAL[15:8];
         default: return ID_VAL[7:0];
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] op;
      logic [23:0] ad;
      int n;
      string tag;
      logic [7:0] exp;
      logic so, si, moe, soe, st;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R6: reset state, both enables low
      chk(!miso_oe && !mosi_oe, "R6", "enables after reset", {miso_oe, mosi_oe}, 0);

      // R10: fill the image through the load port
      for (int i = 0; i < 256; i++) load(8'(i), 8'((i * 29 + 7) ^ (i >> 2)));

      for (int v = 0; v < NV; v++) begin
         op = VECS[v][35:28];
         ad = VECS[v][27:4];
         n  = int'(VECS[v][3:0]);
         tag = (op == C_ID) ? "R3" : (op == C_FAST) ? "R4" : (op == C_DUAL) ? "R5" : "R2";
         xfer(op, ad, n);
         chk(!hdr_oe, "R6", "enable during command/address/dummy", hdr_oe, 0);
         if (tag == "R2") begin
            chk(!any_miso_oe && !any_mosi_oe, "R2", "unsupported command drives",
                {any_miso_oe, any_mosi_oe}, 0);
         end else begin
            for (int k = 0; k < n; k++) begin
               exp = (op == C_ID) ? id_at(k) : img[8'(ad[7:0] + 8'(k))];
               chk(rx[k] == exp, tag, $sformatf("vec %0d byte %0d", v, k), rx[k], exp);
            end
            chk(all_miso_oe, tag, "miso_oe through data", all_miso_oe, 1);
            chk(all_stable, "R8", "outputs steady in high phase", all_stable, 1);
            if (op == C_DUAL)
               chk(all_mosi_oe, "R5", "mosi_oe through dual data", all_mosi_oe, 1);
            else
               chk(!any_mosi_oe, "R6", "mosi_oe outside dual read", any_mosi_oe, 0);
            if (int'(ad[7:0]) + n > 256)
               chk(rx[n-1] == img[8'(ad[7:0] + 8'(n - 1))], "R7", "wrap past top",
                   rx[n-1], img[8'(ad[7:0] + 8'(n - 1))]);
         end
      end

      // R10: overwrite one byte, read it back
      load(8'h10, 8'hA5);
      xfer(C_FAST, 24'h000010, 1);
      chk(rx[0] == 8'hA5, "R10", "reloaded byte", rx[0], 8'hA5);

      // R1 / R9: partial command word discarded
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < 5; i++) tick(1'b1, so, si, moe, soe, st);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
      xfer(C_FAST, 24'h000040, 1);
      chk(rx[0] == img[8'h40], "R1", "read after partial command", rx[0], img[8'h40]);

      // R9: enables drop in the cycle select rises, mid dual byte
      hdr_oe = 0; all_miso_oe = 1; any_miso_oe = 0;
      all_mosi_oe = 1; any_mosi_oe = 0; all_stable = 1;
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      send_byte(C_DUAL);
      send_byte(8'h00); send_byte(8'h00); send_byte(8'h80); send_byte(8'h00);
      get_bytes(1'b1, 1);
      tick(1'b0, so, si, moe, soe, st);
      tick(1'b0, so, si, moe, soe, st);
      chk(rx[0] == img[8'h80], "R5", "dual byte before abort", rx[0], img[8'h80]);
      chk(miso_oe && mosi_oe, "R5", "enables mid byte", {miso_oe, mosi_oe}, 2'b11);
      @(negedge clk);
      cs_n = 1'b1;
      #1;
      chk(!miso_oe && !mosi_oe, "R9", "enables on deselect", {miso_oe, mosi_oe}, 0);
      repeat (2 * HALF) @(negedge clk);
      xfer(C_ID, 24'h0, 1);
      chk(rx[0] == ID_VAL[23:16], "R3", "id after aborted read", rx[0], ID_VAL[23:16]);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule